// File: doc/BRIEF.md
# Software Watchdog Downcounter Reset

This block guards a processor against runaway software. It holds a down-counter that software must reload regularly. Once the watchdog is active, every tick from a prescaled time base removes one from the count. When the count reaches zero, the block raises a reset request for a fixed number of clocks. After the request ends, the control register returns to its power-up value.

A single control word holds both the activation flag and the count. Bit 0 is the activation flag, where 1 means active. Bits 7:1 hold the count, with bit 1 as its least significant bit. The word comes out of reset as 0xFE, which is the maximum count with the watchdog inactive.

Software activates the watchdog by writing bit 0 as 1. From then on, no write can clear the flag; only the block's own reset pulse, or a system reset, ends the active state. A strap input can force the watchdog active from reset without any software write. The read port returns the live count and the effective activation flag.

Top module: `wdt_top`

## Requirements
- R1: After reset with the strap low, the read port shows 0xFE and the reset request is low. Bit 0 is the activation flag and bits 7:1 are the count.
- R2: With the strap high, the read port shows bit 0 as 1 from reset, and ticks decrement the count with no write needed.
- R3: While active and outside a pulse, each tick without a write lowers the count by exactly one on the next clock.
- R4: While inactive, ticks leave the count unchanged.
- R5: A write while inactive loads the count from bits 7:1 and the activation flag from bit 0.
- R6: A write while active reloads the count from bits 7:1, and the activation flag stays 1 even if bit 0 is written as 0.
- R7: When the watchdog is active with a count of zero, the reset request goes high on the next clock edge. That is one clock after the edge at which the count became zero.
- R8: When a write and a tick arrive in the same cycle, the write wins and the tick is lost.
- R9: The reset request stays high for exactly PULSE_LEN clocks, and writes and ticks during that time have no effect.
- R10: On the clock where the reset request falls, the count returns to all ones and the stored activation flag to 0. The read port then shows 0xFE, or 0xFF when the strap is high.
- R11: Writes that refresh the count before it reaches zero keep the reset request low for any number of ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| hw_force_i | input | 1 | Strap that forces the watchdog active |
| tick_i | input | 1 | One-cycle strobe from the prescaled time base |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 8 | Control word write data |
| rd_data_o | output | 8 | Current control word: count and effective activation flag |
| rst_req_o | output | 1 | Reset request pulse |

## Verification
The assertions assume the following about the inputs:
- `tick_i` and `wr_en_i` are synchronous single-cycle strobes sampled on the rising clock.
- The strap does not change between system resets.

The stimulus changes inputs only on falling edges and changes the strap only while reset is held. Random writes carry small counts so that expiry, refresh and pulse overlap occur often.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned WDT_CNT_W_DEF   = 7;
  localparam int unsigned WDT_PULSE_DEF   = 4;

  typedef enum logic {
    PH_RUN   = 1'b0,
    PH_PULSE = 1'b1
  } wdt_phase_e;
endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_force,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic             wr_arm,
  input  logic             hold,
  input  logic             reload,
  input  logic             expire,
  output logic [CNT_W-1:0] cnt_q,
  output logic             arm_q,
  output logic             armed
);
  localparam logic [CNT_W-1:0] CNT_INIT = '1;

  assign armed = arm_q | hw_force;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_INIT;
      arm_q <= 1'b0;
    end else if (reload) begin
      cnt_q <= CNT_INIT;
      arm_q <= 1'b0;
    end else if (hold || expire) begin
      cnt_q <= cnt_q;
      arm_q <= arm_q;
    end else if (wr_en) begin
      cnt_q <= wr_cnt;
      arm_q <= arm_q | wr_arm;
    end else if (tick && armed) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  a_r3_tick_decrements: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && tick && !wr_en && !hold && !expire) |=> (cnt_q == $past(cnt_q) - 1'b1));
  a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !wr_en && !reload) |=> $stable(cnt_q));
  a_r6_arm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q && !reload) |=> arm_q);
  a_r9_frozen_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !reload) |=> ($stable(cnt_q) && $stable(arm_q)));
endmodule

// File: rtl/wdt_expiry_pulse.sv
module wdt_expiry_pulse
  import wdt_pkg::*;
#(
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  output logic active,
  output logic last
);
  localparam int unsigned PW = $clog2(PULSE_LEN + 1);
  localparam logic [PW-1:0] LEN_V = PW'(PULSE_LEN);

  logic [PW-1:0] left_q;
  wdt_phase_e    phase;

  assign phase  = (left_q != '0) ? PH_PULSE : PH_RUN;
  assign active = (phase == PH_PULSE);
  assign last   = (left_q == PW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    left_q <= '0;
    else if (active)               left_q <= left_q - 1'b1;
    else if (expire)               left_q <= LEN_V;
  end

  a_r7_expiry_starts_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !active) |=> active);
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W     = WDT_CNT_W_DEF,
  parameter int unsigned PULSE_LEN = WDT_PULSE_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_force_i,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [CNT_W:0]   wr_data_i,
  output logic [CNT_W:0]   rd_data_o,
  output logic             rst_req_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             arm_q, armed, active, last, expire;

  assign expire = armed && (cnt_q == '0) && !active;

  wdt_ctrl_reg #(.CNT_W(CNT_W)) reg_i (
    .clk(clk), .rst_n(rst_n), .hw_force(hw_force_i), .tick(tick_i),
    .wr_en(wr_en_i), .wr_cnt(wr_data_i[CNT_W:1]), .wr_arm(wr_data_i[0]),
    .hold(active), .reload(last), .expire(expire),
    .cnt_q(cnt_q), .arm_q(arm_q), .armed(armed)
  );

  wdt_expiry_pulse #(.PULSE_LEN(PULSE_LEN)) pulse_i (
    .clk(clk), .rst_n(rst_n), .expire(expire), .active(active), .last(last)
  );

  assign rd_data_o = {cnt_q, armed};
  assign rst_req_o = active;

  a_r10_reinit_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req_o) |-> (rd_data_o[CNT_W:1] == '1 && !arm_q));
  a_r7_zero_count_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && cnt_q == '0 && !rst_req_o) |=> rst_req_o);
endmodule

// File: tb/wdt_top_tb_top.sv
module wdt_top_tb_top;
  localparam int CW = 7;
  localparam int PL = 4;

  logic clk = 1'b0, rst_n = 1'b0, force_s = 1'b0, tick = 1'b0, wr = 1'b0;
  logic [CW:0] wd = '0;
  logic [CW:0] rd;
  logic rreq;
  int errors = 0, checks = 0;
  bit done = 0;

  logic [CW-1:0] m_cnt;
  logic m_arm;
  int m_pl;

  always #2 clk = ~clk;

  wdt_top #(.CNT_W(CW), .PULSE_LEN(PL)) dut_i (
    .clk(clk), .rst_n(rst_n), .hw_force_i(force_s), .tick_i(tick),
    .wr_en_i(wr), .wr_data_i(wd), .rd_data_o(rd), .rst_req_o(rreq)
  );

  function automatic logic [CW:0] exp_rd();
    return {m_cnt, m_arm | force_s};
  endfunction

  task automatic chk(input string tag, input logic [CW:0] act, input logic [CW:0] ex);
    checks++;
    if (act !== ex) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, ex);
    end
  endtask

  function automatic void model_step(input logic w, input logic [CW:0] d, input logic t);
    if (m_pl != 0) begin
      m_pl--;
      if (m_pl == 0) begin m_cnt = '1; m_arm = 1'b0; end
    end else if ((m_arm | force_s) && m_cnt == '0) begin
      m_pl = PL;
    end else if (w) begin
      m_cnt = d[CW:1];
      m_arm = m_arm | d[0];
    end else if (t && (m_arm | force_s)) begin
      m_cnt = m_cnt - 1'b1;
    end
  endfunction

  task automatic do_reset(input logic f);
    rst_n = 1'b0; force_s = f; wr = 0; tick = 0;
    m_cnt = '1; m_arm = 1'b0; m_pl = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(input string tag, input logic w, input logic [CW:0] d, input logic t);
    wr = w; wd = d; tick = t;
    model_step(w, d, t);
    @(negedge clk);
    wr = 0; tick = 0;
    chk(tag, rd, exp_rd());
    chk(tag, {{CW{1'b0}}, rreq}, {{CW{1'b0}}, m_pl != 0});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int hi;
    void'($urandom(32'd2024));
    do_reset(1'b0);
    @(negedge clk);
    chk("R1", rd, 8'hFE);
    chk("R1", {7'd0, rreq}, 8'h00);
    for (int i = 0; i < 3; i++) step("R4", 0, '0, 1);
    chk("R4", rd, 8'hFE);
    step("R5", 1, 8'h0A, 0);
    chk("R5", rd, 8'h0A);
    step("R5", 1, 8'h0B, 0);
    chk("R5", rd, 8'h0B);
    step("R3", 0, '0, 1);
    chk("R3", rd, 8'h09);
    step("R6", 1, 8'h20, 0);
    chk("R6", rd, 8'h21);
    step("R8", 1, 8'h30, 1);
    chk("R8", rd, 8'h31);
    // R11: keep refreshing across many ticks
    for (int i = 0; i < 60; i++) begin
      step("R11", 0, '0, 1);
      if (i % 5 == 4) step("R11", 1, 8'h0D, 0);
      if (rreq) chk("R11", 8'h01, 8'h00);
    end
    // R7: count 3, three ticks then pulse on the next edge
    step("R7", 1, 8'h07, 0);
    for (int i = 0; i < 3; i++) step("R7", 0, '0, 1);
    chk("R7", {7'd0, rreq}, 8'h00);
    chk("R7", rd, 8'h01);
    step("R7", 1, 8'h15, 1);
    chk("R7", {7'd0, rreq}, 8'h01);
    hi = 1;
    for (int i = 0; i < PL + 2; i++) begin
      step("R9", 1, 8'h55, 1);
      if (rreq) hi++;
      else if (i == PL - 1) chk("R10", rd, 8'hFE);
    end
    chk("R9", 8'(hi), 8'(PL));
    do_reset(1'b1);
    @(negedge clk);
    chk("R2", rd, 8'hFF);
    step("R2", 0, '0, 1);
    chk("R2", rd, 8'hFD);
    step("R2", 1, 8'h02, 0);
    chk("R2", rd, 8'h03);
    step("R2", 0, '0, 1);
    step("R2", 0, '0, 0);
    chk("R2", {7'd0, rreq}, 8'h01);
    for (int i = 0; i < PL; i++) step("R10", 0, '0, 0);
    chk("R10", rd, 8'hFF);
    // constrained random mixed phase
    do_reset(1'b0);
    for (int i = 0; i < 4000; i++) begin
      logic w, t;
      logic [CW:0] d;
      if (i % 900 == 899) do_reset(1'($urandom % 2));
      w = ($urandom % 8) == 0;
      t = ($urandom % 2) == 0;
      d = {4'd0, 3'($urandom), 1'($urandom)};
      if (($urandom % 4) == 0) d = 8'($urandom);
      step("R3/R6/R9 random", w, d, t);
    end
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule